// File: doc/BRIEF.md
# I2C Start/Stop Condition Unit

This block sits beside the byte shifter of an I2C controller. It watches already-synchronized samples of the SDA and SCL lines and recognises start and stop conditions. An edge on SDA counts as a condition only if SCL was high long enough before it and stays high long enough after it. Both kinds of condition raise the same interrupt pulse. A bus-busy flag shows which kind was seen: it is set by a start and cleared by a stop.

The same unit can put start, repeated-start and stop conditions on the bus. Each condition has its own request strobe, which sets a pending bit. A pending condition is driven only while the output-select input is high. While output-select is low, the two drive-enable outputs follow the serial path's own drive signals. A pending bit clears itself when its sequence ends, and a one-cycle done pulse is raised in that cycle.

Every time count is in sampling cycles. A sampling cycle is either each clock-enable tick or every second tick, chosen by a select input.

Top module: `i2c_cond_unit`

## Requirements
- R1: A start is recognised when SDA goes from 1 to 0 at a sample where SCL is 1. One clock after the last hold sample, `cond_irq` pulses for one clock and `bus_busy` becomes 1.
- R2: A stop is recognised when SDA goes from 0 to 1 at a sample where SCL is 1. `cond_irq` pulses for one clock and `bus_busy` becomes 0. `bus_busy` changes only together with `cond_irq`.
- R3: An SDA edge is rejected unless SCL was 1 on at least SETUP_CNT consecutive samples before the sample that shows the edge. A rejected edge gives no pulse and leaves `bus_busy` unchanged.
- R4: After an accepted edge, SCL must be 1 on each of the next HOLD_CNT samples. If SCL is 0 on any of them, the condition is dropped with no pulse.
- R5: With `div2_sel`=0, every clock with `tick`=1 is a sample. With `div2_sel`=1, only every second tick is a sample. Tick parity starts at reset.
- R6: While `out_sel`=0, `sda_drive_low` and `scl_drive_low` equal `ser_sda_low` and `ser_scl_low`. Pending requests stay pending and no sequence advances.
- R7: A start sequence has two phases, written (SDA low, SCL low): (0,0) for SETUP_CNT+1 samples, then (1,0) for HOLD_CNT+1 samples. It ends at (1,1).
- R8: A repeated start first drives (0,1) for SETUP_CNT+1 samples and then runs the start sequence of R7.
- R9: A stop sequence drives (1,1) for SETUP_CNT+1 samples, then (1,0) for SETUP_CNT+1 samples, then (0,0) for HOLD_CNT+1 samples. It ends at (0,0).
- R10: The bits of `req_pend` are: bit 0 start, bit 1 repeated start, bit 2 stop. A pending bit clears only in the clock where its sequence ends, and `gen_done` pulses for one clock in that clock.
- R11: When several requests are pending, they are served in this order: stop, then repeated start, then start.
- R12: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Clock enable from the serial prescaler |
| div2_sel | input | 1 | 1: sample on every second tick |
| sda_in | input | 1 | Synchronized SDA sample |
| scl_in | input | 1 | Synchronized SCL sample |
| ser_sda_low | input | 1 | SDA pull-low request from the serial path |
| ser_scl_low | input | 1 | SCL pull-low request from the serial path |
| req_start | input | 1 | Strobe: request a start |
| req_rstart | input | 1 | Strobe: request a repeated start |
| req_stop | input | 1 | Strobe: request a stop |
| out_sel | input | 1 | 1: drive the generated condition levels |
| sda_drive_low | output | 1 | Pull SDA low |
| scl_drive_low | output | 1 | Pull SCL low |
| cond_irq | output | 1 | One-clock pulse on a start or stop |
| bus_busy | output | 1 | 1 after a start, 0 after a stop |
| gen_done | output | 1 | One-clock pulse when a sequence ends |
| req_pend | output | 3 | Pending requests {stop, rstart, start} |

## Verification
The bench builds the unit with SETUP_CNT=3 and HOLD_CNT=5. Because the two windows differ, a design that swaps them or miscounts by one sample misses the window edges that the bench drives on each side. The bench wires the drive outputs back onto the sampled lines, so every generated sequence also passes through the detector. Phase lengths one sample longer than the windows are therefore checked as detected conditions, in both sampling modes and under sparse ticks.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_RS_PRE = 3'd1,
    PH_ST_SU  = 3'd2,
    PH_ST_HD  = 3'd3,
    PH_SP_PRE = 3'd4,
    PH_SP_SU  = 3'd5,
    PH_SP_HD  = 3'd6
  } gen_phase_e;

  localparam int NUM_KINDS = 3;
  localparam logic [1:0] KIND_START  = 2'd0;
  localparam logic [1:0] KIND_RSTART = 2'd1;
  localparam logic [1:0] KIND_STOP   = 2'd2;

endpackage

// File: rtl/i2c_cond_sampler.sv
module i2c_cond_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic div2_sel,
  output logic samp
);

  logic phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    if (tick) phase_d = ~phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= phase_d;
  end

  assign samp = tick & (~div2_sel | phase_q);

endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect #(
  parameter int SETUP_CNT = 4,
  parameter int HOLD_CNT  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic samp,
  input  logic sda_in,
  input  logic scl_in,
  output logic irq,
  output logic busy
);

  localparam int HIW = $clog2(SETUP_CNT + 1);
  localparam int HDW = $clog2(HOLD_CNT + 1);
  localparam logic [HIW-1:0] HI_MAX  = HIW'(SETUP_CNT);
  localparam logic [HDW-1:0] HD_LAST = HDW'(HOLD_CNT - 1);

  logic           prev_sda_q, prev_sda_d;
  logic [HIW-1:0] hi_q, hi_d;
  logic           armed_q, armed_d;
  logic           kind_q, kind_d;
  logic [HDW-1:0] hold_q, hold_d;
  logic           irq_q, irq_d;
  logic           busy_q, busy_d;
  logic           sda_edge;
  logic           fire;

  // An SDA change qualifies only after a saturated run of SCL-high samples.
  assign sda_edge = (sda_in != prev_sda_q) && scl_in && (hi_q == HI_MAX);

  always_comb begin
    prev_sda_d = prev_sda_q;
    hi_d       = hi_q;
    armed_d    = armed_q;
    kind_d     = kind_q;
    hold_d     = hold_q;
    fire       = 1'b0;
    if (samp) begin
      prev_sda_d = sda_in;
      if (!scl_in)              hi_d = '0;
      else if (hi_q != HI_MAX)  hi_d = hi_q + HIW'(1);
      if (sda_edge) begin
        armed_d = 1'b1;
        kind_d  = ~sda_in;
        hold_d  = '0;
      end else if (armed_q) begin
        if (!scl_in) begin
          armed_d = 1'b0;
        end else if (hold_q == HD_LAST) begin
          fire    = 1'b1;
          armed_d = 1'b0;
        end else begin
          hold_d = hold_q + HDW'(1);
        end
      end
    end
    irq_d  = fire;
    busy_d = fire ? kind_q : busy_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_sda_q <= 1'b1;
      hi_q       <= '0;
      armed_q    <= 1'b0;
      kind_q     <= 1'b0;
      hold_q     <= '0;
      irq_q      <= 1'b0;
      busy_q     <= 1'b0;
    end else begin
      prev_sda_q <= prev_sda_d;
      hi_q       <= hi_d;
      armed_q    <= armed_d;
      kind_q     <= kind_d;
      hold_q     <= hold_d;
      irq_q      <= irq_d;
      busy_q     <= busy_d;
    end
  end

  assign irq  = irq_q;
  assign busy = busy_q;

endmodule

// File: rtl/i2c_cond_gen.sv
module i2c_cond_gen
  import i2c_cond_pkg::*;
#(
  parameter int SETUP_CNT = 4,
  parameter int HOLD_CNT  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 samp,
  input  logic                 out_sel,
  input  logic [NUM_KINDS-1:0] set_req,
  output logic                 sda_lo,
  output logic                 scl_lo,
  output logic                 done,
  output logic [NUM_KINDS-1:0] pend
);

  localparam int CMAX = (SETUP_CNT > HOLD_CNT) ? SETUP_CNT : HOLD_CNT;
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] SU_LAST = CW'(SETUP_CNT);
  localparam logic [CW-1:0] HD_LAST = CW'(HOLD_CNT);

  gen_phase_e           st_q, st_d;
  logic [CW-1:0]        cnt_q, cnt_d;
  logic                 sda_q, sda_d;
  logic                 scl_q, scl_d;
  logic [1:0]           kind_q, kind_d;
  logic                 done_q, done_d;
  logic [NUM_KINDS-1:0] pend_q, pend_d;
  logic [NUM_KINDS-1:0] clr;
  logic [CW-1:0]        last;

  // Hold phases last one sample beyond the hold window, other phases beyond setup.
  always_comb begin
    if (st_q == PH_ST_HD || st_q == PH_SP_HD) last = HD_LAST;
    else                                      last = SU_LAST;
  end

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    sda_d  = sda_q;
    scl_d  = scl_q;
    kind_d = kind_q;
    done_d = 1'b0;
    clr    = '0;
    if (out_sel) begin
      if (st_q == PH_IDLE) begin
        cnt_d = '0;
        if (pend_q[KIND_STOP]) begin
          st_d = PH_SP_PRE;  kind_d = KIND_STOP;   sda_d = 1'b1; scl_d = 1'b1;
        end else if (pend_q[KIND_RSTART]) begin
          st_d = PH_RS_PRE;  kind_d = KIND_RSTART; sda_d = 1'b0; scl_d = 1'b1;
        end else if (pend_q[KIND_START]) begin
          st_d = PH_ST_SU;   kind_d = KIND_START;  sda_d = 1'b0; scl_d = 1'b0;
        end
      end else if (samp) begin
        if (cnt_q == last) begin
          cnt_d = '0;
          case (st_q)
            PH_RS_PRE: begin st_d = PH_ST_SU; sda_d = 1'b0; scl_d = 1'b0; end
            PH_ST_SU:  begin st_d = PH_ST_HD; sda_d = 1'b1; scl_d = 1'b0; end
            PH_ST_HD: begin
              st_d = PH_IDLE; sda_d = 1'b1; scl_d = 1'b1;
              done_d = 1'b1;  clr = NUM_KINDS'(1) << kind_q;
            end
            PH_SP_PRE: begin st_d = PH_SP_SU; sda_d = 1'b1; scl_d = 1'b0; end
            PH_SP_SU:  begin st_d = PH_SP_HD; sda_d = 1'b0; scl_d = 1'b0; end
            PH_SP_HD: begin
              st_d = PH_IDLE; sda_d = 1'b0; scl_d = 1'b0;
              done_d = 1'b1;  clr = NUM_KINDS'(1) << kind_q;
            end
            default: st_d = PH_IDLE;
          endcase
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
    end
    pend_d = (pend_q & ~clr) | set_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PH_IDLE;
      cnt_q  <= '0;
      sda_q  <= 1'b0;
      scl_q  <= 1'b0;
      kind_q <= KIND_START;
      done_q <= 1'b0;
      pend_q <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      sda_q  <= sda_d;
      scl_q  <= scl_d;
      kind_q <= kind_d;
      done_q <= done_d;
      pend_q <= pend_d;
    end
  end

  assign sda_lo = sda_q;
  assign scl_lo = scl_q;
  assign done   = done_q;
  assign pend   = pend_q;

endmodule

// File: rtl/i2c_cond_unit.sv
module i2c_cond_unit
  import i2c_cond_pkg::*;
#(
  parameter int SETUP_CNT = 4,
  parameter int HOLD_CNT  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       div2_sel,
  input  logic       sda_in,
  input  logic       scl_in,
  input  logic       ser_sda_low,
  input  logic       ser_scl_low,
  input  logic       req_start,
  input  logic       req_rstart,
  input  logic       req_stop,
  input  logic       out_sel,
  output logic       sda_drive_low,
  output logic       scl_drive_low,
  output logic       cond_irq,
  output logic       bus_busy,
  output logic       gen_done,
  output logic [2:0] req_pend
);

  logic                 samp;
  logic                 gen_sda_lo, gen_scl_lo;
  logic [NUM_KINDS-1:0] set_req;

  assign set_req = {req_stop, req_rstart, req_start};

  i2c_cond_sampler u_sampler (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .div2_sel (div2_sel),
    .samp     (samp)
  );

  i2c_cond_detect #(
    .SETUP_CNT (SETUP_CNT),
    .HOLD_CNT  (HOLD_CNT)
  ) u_detect (
    .clk    (clk),
    .rst_n  (rst_n),
    .samp   (samp),
    .sda_in (sda_in),
    .scl_in (scl_in),
    .irq    (cond_irq),
    .busy   (bus_busy)
  );

  i2c_cond_gen #(
    .SETUP_CNT (SETUP_CNT),
    .HOLD_CNT  (HOLD_CNT)
  ) u_gen (
    .clk     (clk),
    .rst_n   (rst_n),
    .samp    (samp),
    .out_sel (out_sel),
    .set_req (set_req),
    .sda_lo  (gen_sda_lo),
    .scl_lo  (gen_scl_lo),
    .done    (gen_done),
    .pend    (req_pend)
  );

  assign sda_drive_low = out_sel ? gen_sda_lo : ser_sda_low;
  assign scl_drive_low = out_sel ? gen_scl_lo : ser_scl_low;

endmodule

// File: rtl/i2c_cond_unit_chk.sv
module i2c_cond_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       out_sel,
  input logic       cond_irq,
  input logic       bus_busy,
  input logic       gen_done,
  input logic [2:0] req_pend
);

  AST_BUSY_MOVES_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bus_busy) |-> cond_irq); // R2

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cond_irq |=> !cond_irq); // R1

  AST_NO_DONE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(out_sel) |-> !gen_done); // R6

  AST_PEND_DROP_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(req_pend) & ~req_pend) != 3'b000) |-> gen_done); // R10

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    gen_done |=> !gen_done); // R7

  AST_SINGLE_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
    gen_done |-> ($countones($past(req_pend) & ~req_pend) <= 1)); // R11

endmodule

bind i2c_cond_unit i2c_cond_unit_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .out_sel  (out_sel),
  .cond_irq (cond_irq),
  .bus_busy (bus_busy),
  .gen_done (gen_done),
  .req_pend (req_pend)
);

// File: tb/i2c_cond_unit_test.sv
`timescale 1ns/1ps
module i2c_cond_unit_test;

  localparam int SU = 3;
  localparam int HD = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic tick, div2_sel, ser_sda_low, ser_scl_low;
  logic req_start, req_rstart, req_stop, out_sel;
  logic ext_sda, ext_scl;
  logic sda_drive_low, scl_drive_low, cond_irq, bus_busy, gen_done;
  logic [2:0] req_pend;
  wire sda_line = ext_sda & ~sda_drive_low;
  wire scl_line = ext_scl & ~scl_drive_low;

  always #2.5 clk = ~clk;

  i2c_cond_unit #(.SETUP_CNT(SU), .HOLD_CNT(HD)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .div2_sel(div2_sel),
    .sda_in(sda_line), .scl_in(scl_line),
    .ser_sda_low(ser_sda_low), .ser_scl_low(ser_scl_low),
    .req_start(req_start), .req_rstart(req_rstart), .req_stop(req_stop),
    .out_sel(out_sel), .sda_drive_low(sda_drive_low), .scl_drive_low(scl_drive_low),
    .cond_irq(cond_irq), .bus_busy(bus_busy), .gen_done(gen_done), .req_pend(req_pend)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit tick_sparse = 0;
  int irq_seen = 0;
  int done_seen = 0;
  int fell_q[$];
  logic [2:0] prev_pend = 3'b000;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // ---------------- behavioural reference model ----------------
  bit m_phase, m_samp, m_prev_sda, m_armed, m_kind, m_fire, m_irq, m_busy, m_done;
  int m_hi, m_hold, m_cnt, m_srv;
  logic [1:0] m_lvl, m_fin;
  logic [2:0] m_pend, m_clr;
  int q_lvl[$];
  int q_len[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_prev_sda = 1; m_hi = 0; m_armed = 0; m_kind = 0; m_hold = 0;
      m_irq = 0; m_busy = 0; m_done = 0; m_cnt = 0; m_srv = 0;
      m_lvl = 2'b00; m_fin = 2'b00; m_pend = 3'b000;
      q_lvl.delete(); q_len.delete();
    end else begin
      m_samp = tick && (!div2_sel || m_phase);
      if (tick) m_phase = !m_phase;
      m_fire = 0;
      if (m_samp) begin
        if ((sda_line != m_prev_sda) && scl_line && m_hi >= SU) begin
          m_armed = 1; m_kind = !sda_line; m_hold = 0;
        end else if (m_armed) begin
          if (!scl_line) m_armed = 0;
          else begin
            m_hold++;
            if (m_hold == HD) begin m_fire = 1; m_armed = 0; end
          end
        end
        m_hi = scl_line ? ((m_hi < SU) ? m_hi + 1 : SU) : 0;
        m_prev_sda = sda_line;
      end
      m_irq = m_fire;
      if (m_fire) m_busy = m_kind;
      m_done = 0; m_clr = 3'b000;
      if (out_sel) begin
        if (q_len.size() == 0) begin
          if (m_pend[2]) begin
            m_srv = 2; m_fin = 2'b00;
            q_lvl.push_back(3); q_len.push_back(SU + 1);
            q_lvl.push_back(2); q_len.push_back(SU + 1);
            q_lvl.push_back(0); q_len.push_back(HD + 1);
          end else if (m_pend[1]) begin
            m_srv = 1; m_fin = 2'b11;
            q_lvl.push_back(1); q_len.push_back(SU + 1);
            q_lvl.push_back(0); q_len.push_back(SU + 1);
            q_lvl.push_back(2); q_len.push_back(HD + 1);
          end else if (m_pend[0]) begin
            m_srv = 0; m_fin = 2'b11;
            q_lvl.push_back(0); q_len.push_back(SU + 1);
            q_lvl.push_back(2); q_len.push_back(HD + 1);
          end
          if (q_len.size() != 0) begin m_lvl = 2'(q_lvl[0]); m_cnt = 0; end
        end else if (m_samp) begin
          m_cnt++;
          if (m_cnt == q_len[0]) begin
            m_cnt = 0;
            void'(q_lvl.pop_front());
            void'(q_len.pop_front());
            if (q_len.size() == 0) begin
              m_done = 1; m_lvl = m_fin; m_clr[m_srv] = 1'b1;
            end else m_lvl = 2'(q_lvl[0]);
          end
        end
      end
      m_pend = (m_pend & ~m_clr) | {req_stop, req_rstart, req_start};
    end
  end

  // per-cycle comparison and event monitors, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1 cond_irq", int'(cond_irq), int'(m_irq));
      chk("R2 bus_busy", int'(bus_busy), int'(m_busy));
      chk("R7 sda_drive_low", int'(sda_drive_low), int'(out_sel ? m_lvl[1] : ser_sda_low));
      chk("R9 scl_drive_low", int'(scl_drive_low), int'(out_sel ? m_lvl[0] : ser_scl_low));
      chk("R10 gen_done", int'(gen_done), int'(m_done));
      chk("R11 req_pend", int'(req_pend), int'(m_pend));
      if (cond_irq) irq_seen++;
      if (gen_done) done_seen++;
      for (int b = 0; b < 3; b++) if (prev_pend[b] && !req_pend[b]) fell_q.push_back(b);
      prev_pend = req_pend;
    end
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
      cyc++;
      tick = tick_sparse ? (cyc % 3 == 0) : 1'b1;
      req_start = 0; req_rstart = 0; req_stop = 0;
    end
  endtask

  task automatic wait_done();
    int k = 0;
    do begin step(); k++; end while (!gen_done && k < 600);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  int base;

  initial begin
    rst_n = 0; tick = 1; div2_sel = 0; ser_sda_low = 0; ser_scl_low = 0;
    req_start = 0; req_rstart = 0; req_stop = 0; out_sel = 0;
    ext_sda = 1; ext_scl = 1;
    step(3);
    chk("R12 reset outputs", int'({sda_drive_low, scl_drive_low, cond_irq, bus_busy, gen_done, req_pend}), 0);
    rst_n = 1;
    step(10);

    // R1: start, setup exactly SU samples
    base = irq_seen;
    ext_scl = 0; step(2); ext_scl = 1; step(SU); ext_sda = 0; step(HD + 4);
    chk("R1 start irq count", irq_seen - base, 1);
    chk("R1 busy after start", int'(bus_busy), 1);
    // R2: stop
    base = irq_seen;
    ext_scl = 0; step(2); ext_scl = 1; step(SU); ext_sda = 1; step(HD + 4);
    chk("R2 stop irq count", irq_seen - base, 1);
    chk("R2 busy after stop", int'(bus_busy), 0);
    // R3: setup one short
    base = irq_seen;
    ext_scl = 0; step(2); ext_scl = 1; step(SU - 1); ext_sda = 0; step(HD + 4);
    chk("R3 short setup irq", irq_seen - base, 0);
    chk("R3 short setup busy", int'(bus_busy), 0);
    // R4: hold one short, then exactly enough
    base = irq_seen;
    ext_scl = 0; step(2); ext_sda = 1; step(1); ext_scl = 1; step(SU + 2);
    ext_sda = 0; step(HD); ext_scl = 0; step(4);
    chk("R4 short hold irq", irq_seen - base, 0);
    chk("R4 short hold busy", int'(bus_busy), 0);
    base = irq_seen;
    ext_sda = 1; step(1); ext_scl = 1; step(SU + 2);
    ext_sda = 0; step(HD + 1); ext_scl = 0; step(4);
    chk("R4 full hold irq", irq_seen - base, 1);
    chk("R4 full hold busy", int'(bus_busy), 1);
    ext_scl = 1; step(SU + 2); ext_sda = 1; step(HD + 4);
    chk("R2 release busy", int'(bus_busy), 0);

    // R5: divided sampling
    div2_sel = 1;
    base = irq_seen;
    ext_scl = 0; step(2); ext_scl = 1; step(SU); ext_sda = 0; step(2 * HD + 6);
    chk("R5 div2 short setup irq", irq_seen - base, 0);
    ext_scl = 0; step(2); ext_sda = 1; step(1); ext_scl = 1; step(2 * SU + 2);
    ext_sda = 0; step(2 * HD + 4);
    chk("R5 div2 start irq", irq_seen - base, 1);
    chk("R5 div2 busy", int'(bus_busy), 1);
    tick_sparse = 1;
    base = irq_seen;
    ext_sda = 1; step(6 * HD + 12);
    chk("R5 sparse stop irq", irq_seen - base, 1);
    chk("R5 sparse busy", int'(bus_busy), 0);
    tick_sparse = 0; div2_sel = 0; step(4);

    // R6: deselected outputs follow the serial path, request waits
    ser_sda_low = 1; ser_scl_low = 1; step(1);
    chk("R6 pass sda", int'(sda_drive_low), 1);
    chk("R6 pass scl", int'(scl_drive_low), 1);
    ser_sda_low = 0; ser_scl_low = 0;
    base = done_seen;
    req_start = 1; #0; @(posedge clk); #1; req_start = 0; step(30);
    chk("R6 pending held", int'(req_pend), 1);
    chk("R6 no done", done_seen - base, 0);

    // R7: start generation through the loop-back
    base = irq_seen;
    out_sel = 1; wait_done(); step(2);
    chk("R7 start pend cleared", int'(req_pend), 0);
    chk("R7 start detected", irq_seen - base, 1);
    chk("R7 busy", int'(bus_busy), 1);
    chk("R7 lines held", int'({sda_drive_low, scl_drive_low}), 3);

    // R8: repeated start
    base = irq_seen;
    req_rstart = 1; @(posedge clk); #1; req_rstart = 0; wait_done(); step(2);
    chk("R8 restart detected", irq_seen - base, 1);
    chk("R8 lines held", int'({sda_drive_low, scl_drive_low}), 3);

    // R11: all three at once
    fell_q.delete();
    base = done_seen;
    req_start = 1; req_rstart = 1; req_stop = 1; @(posedge clk); #1;
    req_start = 0; req_rstart = 0; req_stop = 0;
    wait_done(); wait_done(); wait_done(); step(2);
    chk("R10 three done pulses", done_seen - base, 3);
    chk("R11 order size", fell_q.size(), 3);
    if (fell_q.size() == 3) begin
      chk("R11 first stop", fell_q[0], 2);
      chk("R11 second rstart", fell_q[1], 1);
      chk("R11 third start", fell_q[2], 0);
    end

    // R9: stop releases the bus
    base = irq_seen;
    req_stop = 1; @(posedge clk); #1; req_stop = 0; wait_done(); step(3);
    chk("R9 stop detected", irq_seen - base, 1);
    chk("R9 busy cleared", int'(bus_busy), 0);
    chk("R9 lines released", int'({sda_drive_low, scl_drive_low}), 0);
    chk("R10 pend empty", int'(req_pend), 0);

    step(5);
    report();
    $finish;
  end

endmodule